// File: doc/BRIEF.md
# Dual-Clock-Input Parallel-Load Shift Register

This block is an eight-stage register held inside a synchronous design. On each effective clock event it either captures a whole parallel byte or shifts one serial bit in at the first stage and moves every other stage along by one. Only the final stage is driven to the output. A debug vector also shows all the stages.

The clock has two inputs, and either one can serve as the clock. The effective clock is the OR of the two, so while one input is held high it blocks the other. Both inputs are external levels. A free-running system clock samples them through a two-flop synchronizer. The register acts on a rising edge of their synchronized OR. The mode select, serial bit and parallel byte are sampled in the same system cycle as that edge.

An active-low clear empties the register at once. Its release is taken up synchronously. A clock level already high when clear is released does not count as an edge.

Top module: `dualclk_shift_reg`

## Requirements
- R1: While `clear_n` is low, every stage reads 0 at once, with no system-clock edge needed, whatever the other inputs do.
- R2: After `clear_n` is released, a clock input that was already high during clear is not taken as a rising edge. The stages stay at 0 until a real low-to-high transition of the effective clock.
- R3: The effective clock is `clk_a | clk_b`. A rise of either input while the other is low is a clock event.
- R4: While one clock input is held high, a rising edge on the other input changes no stage.
- R5: On a clock event with `shift_sel` = 0, stage k takes `par_in[k]`. Stage A is bit 0 and stage H is bit 7.
- R6: On a clock event with `shift_sel` = 1, stage A takes `ser_in` and stage k takes the old stage k-1. Old stage G moves to H.
- R7: Without a clock event, all stages keep their values, whatever the select, serial or parallel inputs do.
- R8: `last_q` always equals stage H, which is `stages_q[7]`.
- R9: A clock input that changes just before a system-clock rising edge is reflected in the stages after the third system-clock rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| clear_n | input | 1 | Active-low clear; asserts asynchronously, releases synchronously |
| shift_sel | input | 1 | 0 = parallel load, 1 = serial shift |
| ser_in | input | 1 | Serial data entering stage A |
| par_in | input | 8 | Parallel data, bit 0 to stage A |
| clk_a | input | 1 | Clock input, ORed with clk_b |
| clk_b | input | 1 | Clock input, ORed with clk_a |
| last_q | output | 1 | Stage H |
| stages_q | output | 8 | Debug view of all stages, bit 0 = stage A |

## Verification
The assertions check the following on every system cycle:
- a detected edge lasts a single cycle;
- a detected edge produces a load or a shift with the data sampled in that cycle;
- the stages hold when no edge is detected;
- the stages read zero while clear is low;
- the internal release follows the clear pin.

Several behaviours concern the pins rather than the internal edge signal, and only the bench's scenarios can show them:
- the blocking of one clock input by the other;
- the OR interchangeability of the two inputs, including an inhibit-line rise counting as an edge;
- no false edge when clear is released under a high clock;
- the exact three-edge latency.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int unsigned STAGES_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;
endpackage

// File: rtl/clear_sync.sv
module clear_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic sys_clk,
  input  logic clear_n,
  output logic rst_n
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge sys_clk or negedge clear_n) begin
    if (!clear_n) chain_q <= '0;
    else          chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign rst_n = chain_q[DEPTH-1];

  // internal reset only leaves clear after the pin is high
  p_release_sync_r2: assert property (@(posedge sys_clk)
    $rose(rst_n) |-> clear_n);
endmodule

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
  parameter int unsigned N_IN  = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic            sys_clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] raw_clk,
  output logic            level,
  output logic            step
);
  logic [N_IN-1:0][DEPTH-1:0] chain_q;
  logic [N_IN-1:0]            synced;
  logic                       prev_q;

  always_ff @(posedge sys_clk) begin
    for (int i = 0; i < N_IN; i++) begin
      chain_q[i] <= {chain_q[i][DEPTH-2:0], raw_clk[i]};
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) synced[i] = chain_q[i][DEPTH-1];
  end

  assign level = |synced;

  // history follows the level during clear, so a high level at release is no edge
  always_ff @(posedge sys_clk) prev_q <= level;

  assign step = rst_n & level & ~prev_q;

  p_single_pulse_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    step |=> !step);
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             step,
  input  mode_e            mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages
);
  function automatic logic [WIDTH-1:0] next_value(
    input mode_e            m,
    input logic [WIDTH-1:0] cur,
    input logic             ser,
    input logic [WIDTH-1:0] par
  );
    if (m == MODE_LOAD) return par;
    return {cur[WIDTH-2:0], ser};
  endfunction

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)    stages <= '0;
    else if (step) stages <= next_value(mode, stages, ser_in, par_in);
  end

  p_load_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (step && mode == MODE_LOAD) |=> stages == $past(par_in));
  p_shift_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (step && mode == MODE_SHIFT) |=>
      stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});
  p_hold_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !step |=> $stable(stages));
endmodule

// File: rtl/dualclk_shift_reg.sv
module dualclk_shift_reg
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = STAGES_DEF,
  parameter int unsigned SYNC  = SYNC_DEF
) (
  input  logic             sys_clk,
  input  logic             clear_n,
  input  logic             shift_sel,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic             clk_a,
  input  logic             clk_b,
  output logic             last_q,
  output logic [WIDTH-1:0] stages_q
);
  localparam int unsigned N_CLK = 2;

  logic             rst_n;
  logic             clk_level;
  logic             clk_step;
  logic [WIDTH-1:0] stages;
  mode_e            mode;

  assign mode = shift_sel ? MODE_SHIFT : MODE_LOAD;

  clear_sync #(.DEPTH(SYNC)) clr_i (
    .sys_clk (sys_clk),
    .clear_n (clear_n),
    .rst_n   (rst_n)
  );

  clk_edge_sync #(.N_IN(N_CLK), .DEPTH(SYNC)) edge_i (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .raw_clk ({clk_b, clk_a}),
    .level   (clk_level),
    .step    (clk_step)
  );

  shift_core #(.WIDTH(WIDTH)) core_i (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .step    (clk_step),
    .mode    (mode),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .stages  (stages)
  );

  assign stages_q = stages;
  assign last_q   = stages[WIDTH-1];

  p_clear_zero_r1: assert property (@(posedge sys_clk)
    !clear_n |-> stages_q == '0);
  p_edge_needs_level_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clk_step |-> clk_level);
endmodule

// File: tb/dualclk_shift_reg_tb_top.sv
module dualclk_shift_reg_tb_top;
  logic       sys_clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       shift_sel = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       clk_a = 1'b0;
  logic       clk_b = 1'b0;
  logic       last_q;
  logic [7:0] stages_q;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] exp_st = 8'h00;
  logic       exp_lvl = 1'b0;
  bit         done = 1'b0;

  always #10 sys_clk = ~sys_clk;

  dualclk_shift_reg dut_i (
    .sys_clk   (sys_clk),
    .clear_n   (clear_n),
    .shift_sel (shift_sel),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .last_q    (last_q),
    .stages_q  (stages_q)
  );

  function automatic logic [7:0] model_next(input logic [7:0] cur, input logic sel,
                                            input logic ser, input logic [7:0] par);
    logic [7:0] r;
    if (!sel) return par;
    for (int i = 7; i >= 1; i--) r[i] = cur[i-1];
    r[0] = ser;
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (stages_q !== exp) begin
      errors++;
      $display("FAIL %s stages actual=%h expected=%h", tag, stages_q, exp);
    end
    checks++;
    if (last_q !== exp[7]) begin
      errors++;
      $display("FAIL R8 (%s) last_q actual=%b expected=%b", tag, last_q, exp[7]);
    end
  endtask

  task automatic apply(input string tag, input logic a, input logic b, input logic sel,
                       input logic ser, input logic [7:0] par);
    @(negedge sys_clk);
    clk_a = a; clk_b = b; shift_sel = sel; ser_in = ser; par_in = par;
    repeat (4) @(negedge sys_clk);
    if ((a | b) && !exp_lvl) exp_st = model_next(exp_st, sel, ser, par);
    exp_lvl = a | b;
    check(tag, exp_st);
  endtask

  task automatic do_clear(input logic a, input logic b);
    @(negedge sys_clk);
    clk_a = a; clk_b = b;
    par_in = 8'hFF; shift_sel = 1'b0;
    clear_n = 1'b0;
    #1;
    check("R1", 8'h00);
    repeat (3) @(negedge sys_clk);
    check("R1", 8'h00);
    clear_n = 1'b1;
    repeat (6) @(negedge sys_clk);
    exp_st = 8'h00;
    exp_lvl = a | b;
    check("R2", exp_st);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd4711);
    repeat (5) @(negedge sys_clk);
    check("R1", 8'h00);
    clear_n = 1'b1;
    repeat (4) @(negedge sys_clk);

    // R5 load via clk_a, R3 rise of inhibit line while clk_a low is an edge
    apply("R5", 1, 0, 0, 0, 8'hA5);
    apply("R7", 0, 0, 1, 1, 8'h3C);
    apply("R3", 0, 1, 0, 0, 8'h3C);
    // R4: b held high blocks rise of a
    apply("R4", 1, 1, 0, 0, 8'h81);
    apply("R4", 0, 1, 1, 1, 8'h81);
    apply("R4", 1, 1, 1, 1, 8'h81);
    apply("R7", 0, 0, 0, 1, 8'hFF);
    // R6 shifting
    apply("R6", 1, 0, 1, 1, 8'h00);
    apply("R7", 0, 0, 1, 0, 8'h00);
    apply("R6", 0, 1, 1, 0, 8'h00);

    // R9 latency
    apply("R7", 0, 0, 0, 0, 8'h00);
    @(negedge sys_clk);
    clk_a = 1; shift_sel = 0; par_in = ~exp_st;
    @(negedge sys_clk);
    @(negedge sys_clk);
    check("R9", exp_st);
    @(negedge sys_clk);
    exp_st = ~exp_st; exp_lvl = 1'b1;
    check("R9", exp_st);

    // R2: clear released while clock level is high
    do_clear(1, 0);
    apply("R2", 0, 0, 0, 0, 8'h5A);
    apply("R2", 0, 1, 0, 0, 8'h5A);
    do_clear(0, 1);
    do_clear(0, 0);

    for (int n = 0; n < 400; n++) begin
      r = $urandom;
      if (r[7:4] == 4'h0) do_clear(r[0], r[1]);
      else apply("R3/R4/R5/R6/R7", r[0], r[1], r[2], r[3], r[15:8]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule